// File: doc/BRIEF.md
# Serial Configuration Stream Loader

The loader receives a configuration bitstream one bit per rising edge of its configuration clock. It first hunts for a run of at least eight ones. A fixed start code follows the run, and after the code comes a 24-bit total length. Once the header is taken, the loader packs the next bits into fixed-width frame words. It writes each word, with its index, to a configuration-memory write port. When all of its own frames are stored it forwards the remaining stream to a chain output, where a downstream device can pick it up.

A cycle counter starts from zero when reset is released and advances on every clock. Loading ends only when two things are true: the counter has reached the captured length, and every local frame has been written. A timing selector moves the completion flag, and the matching release of the user reset, one clock earlier or one clock later. Two status lines, one active high and one active low, always follow the unshifted match.

The start code is a parameter. Its first bit must be 0, because the first zero after the run of ones is taken as the start of the code. Frame width must be at least 3 and the code width at least 3.

Top module: `cfg_stream_loader`

## Requirements
- R1: The header is found after any run of eight or more ones, followed by the start code (default 4'b0010) and then a 24-bit length. Both the code and the length arrive MSB first.
- R2: A start code that does not match sends the loader back to hunting for ones. No frame write occurs until a valid header has been received.
- R3: The 24-bit length is captured once and stays stable from the end of the header onward.
- R4: The cycle counter is cleared by reset. It counts every rising clock edge after reset is released, so the first sampled bit is count 1.
- R5: Frame bits are packed MSB first. After the edge that samples a frame's last bit, mem_we_o is high for exactly one cycle, carrying that word and its address. Addresses start at 0 and rise by one per frame. Writes stop after NUM_FRAMES words.
- R6: done_o rises on the first edge at which, before that edge, the counter is at least the captured length and all frames have been written. It then stays high. Its edge number is max(length, last frame bit) + 1.
- R7: timing_sel_i 2'b01 compares the counter against length-1, which is one clock earlier. 2'b10 compares against length+1, which is one clock later. 2'b00 and 2'b11 use the length itself. The selector is held constant while loading.
- R8: user_rst_o is high from reset until done_o rises, and is always the inverse of done_o.
- R9: cfg_busy_o is high and cfg_busy_n_o is low until the unshifted match, max(length, last frame bit) + 1, whatever the timing selection. At that point they swap and stay swapped.
- R10: dout_o changes on the falling edge that follows each sampling edge. For header bits and pass-through bits it repeats the sampled bit. For this device's own frame bits it is 1.
- R11: An asynchronous low on rst_ni forces dout_o=1, done_o=0, user_rst_o=1, mem_we_o=0, cfg_busy_o=1 and cfg_busy_n_o=0, and restarts the header hunt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | configuration clock |
| rst_ni | input | 1 | asynchronous active-low reset, starts a new load |
| din_i | input | 1 | serial stream, sampled on rising edge |
| timing_sel_i | input | 2 | completion timing: 00/11 nominal, 01 early, 10 late |
| dout_o | output | 1 | chain output, updated on falling edge |
| mem_we_o | output | 1 | configuration-memory write strobe |
| mem_addr_o | output | AW | frame address of the write |
| mem_data_o | output | FRAME_W | frame word being written |
| done_o | output | 1 | loading complete |
| user_rst_o | output | 1 | user-logic reset, high while loading |
| cfg_busy_o | output | 1 | high while loading (unshifted timing) |
| cfg_busy_n_o | output | 1 | low while loading (unshifted timing) |

## Verification
The last frame write, the switch of the chain output from forced-high to pass-through, and the count match can land on neighbouring or identical edges. This happens when the length is no greater than the bit position of the last frame bit, or when the early option moves the length compare onto that bit. Vector rows with a short length (40) and with a length one past the last frame bit under the early option cause these collisions. On every edge the bench compares the write strobe, the completion flag, the status pair and the chain output against edge numbers it computes from the header size and the length.

// File: rtl/cfg_ld_pkg.sv
`timescale 1ns/1ps
package cfg_ld_pkg;
  typedef enum logic [1:0] {
    HS_SEARCH,
    HS_CODE,
    HS_LEN,
    HS_DONE
  } hdr_state_e;

  localparam logic [1:0] TSEL_EARLY = 2'b01;
  localparam logic [1:0] TSEL_LATE  = 2'b10;
endpackage

// File: rtl/cfg_hdr_parse.sv
`timescale 1ns/1ps
module cfg_hdr_parse
  import cfg_ld_pkg::*;
#(
  parameter int unsigned PRE_ONES = 8,
  parameter int unsigned CODE_W   = 4,
  parameter logic [CODE_W-1:0] PRE_CODE = 4'b0010,
  parameter int unsigned LEN_W    = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             din_i,
  output logic             hdr_done_o,
  output logic [LEN_W-1:0] len_o
);
  localparam int unsigned OW = $clog2(PRE_ONES + 1);
  localparam int unsigned BW = $clog2(LEN_W + 1);

  hdr_state_e        state_q;
  logic [OW-1:0]     ones_q;
  logic [BW-1:0]     bcnt_q;
  logic [CODE_W-2:0] code_sr_q;
  logic [LEN_W-1:0]  len_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= HS_SEARCH;
      ones_q    <= '0;
      bcnt_q    <= '0;
      code_sr_q <= '0;
      len_sr_q  <= '0;
    end else begin
      unique case (state_q)
        HS_SEARCH: begin
          if (din_i) begin
            if (ones_q != OW'(PRE_ONES)) ones_q <= ones_q + 1'b1;
          end else if (ones_q == OW'(PRE_ONES)) begin
            // first zero after the run is the code MSB
            state_q   <= HS_CODE;
            code_sr_q <= '0;
            bcnt_q    <= BW'(1);
          end else begin
            ones_q <= '0;
          end
        end
        HS_CODE: begin
          code_sr_q <= {code_sr_q[CODE_W-3:0], din_i};
          if (bcnt_q == BW'(CODE_W - 1)) begin
            bcnt_q <= '0;
            if ({code_sr_q, din_i} == PRE_CODE) begin
              state_q <= HS_LEN;
            end else begin
              state_q <= HS_SEARCH;
              ones_q  <= din_i ? OW'(1) : '0;
            end
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        HS_LEN: begin
          len_sr_q <= {len_sr_q[LEN_W-2:0], din_i};
          if (bcnt_q == BW'(LEN_W - 1)) state_q <= HS_DONE;
          else bcnt_q <= bcnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign hdr_done_o = (state_q == HS_DONE);
  assign len_o      = len_sr_q;

  AST_LEN_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_done_o |=> (hdr_done_o && $stable(len_o))); // R3
endmodule

// File: rtl/cfg_frame_asm.sv
`timescale 1ns/1ps
module cfg_frame_asm #(
  parameter int unsigned FRAME_W    = 8,
  parameter int unsigned NUM_FRAMES = 4,
  parameter int unsigned AW         = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               din_i,
  input  logic               hdr_done_i,
  output logic               we_o,
  output logic [AW-1:0]      addr_o,
  output logic [FRAME_W-1:0] data_o,
  output logic               frames_done_o
);
  localparam int unsigned BCW = $clog2(FRAME_W);
  localparam int unsigned FIW = $clog2(NUM_FRAMES + 1);

  logic [FRAME_W-2:0] sr_q;
  logic [BCW-1:0]     bcnt_q;
  logic [FIW-1:0]     fidx_q;
  logic               we_q, fdone_q;
  logic [AW-1:0]      addr_q;
  logic [FRAME_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      bcnt_q  <= '0;
      fidx_q  <= '0;
      we_q    <= 1'b0;
      fdone_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      we_q <= 1'b0;
      if (hdr_done_i && !fdone_q) begin
        sr_q <= {sr_q[FRAME_W-3:0], din_i};
        if (bcnt_q == BCW'(FRAME_W - 1)) begin
          bcnt_q <= '0;
          we_q   <= 1'b1;
          data_q <= {sr_q, din_i};
          addr_q <= fidx_q[AW-1:0];
          fidx_q <= fidx_q + 1'b1;
          if (fidx_q == FIW'(NUM_FRAMES - 1)) fdone_q <= 1'b1;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  assign we_o          = we_q;
  assign addr_o        = addr_q;
  assign data_o        = data_q;
  assign frames_done_o = fdone_q;

  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_q |=> !we_q); // R5
  AST_NO_WRITE_AFTER_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fdone_q |=> !we_q); // R5
endmodule

// File: rtl/cfg_done_ctrl.sv
`timescale 1ns/1ps
module cfg_done_ctrl
  import cfg_ld_pkg::*;
#(
  parameter int unsigned LEN_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] len_i,
  input  logic             frames_done_i,
  input  logic [1:0]       timing_sel_i,
  output logic             done_o,
  output logic             stat_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             done_q, stat_q;
  logic [LEN_W+1:0] lhs, rhs;
  logic             reach, nom_reach;

  always_comb begin
    lhs = {2'b00, cnt_q};
    rhs = {2'b00, len_i};
    if (timing_sel_i == TSEL_EARLY) lhs = lhs + 1'b1;
    if (timing_sel_i == TSEL_LATE)  rhs = rhs + 1'b1;
    reach     = (lhs >= rhs);
    nom_reach = (cnt_q >= len_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (!(done_q && stat_q) && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
      if (frames_done_i && reach)     done_q <= 1'b1;
      if (frames_done_i && nom_reach) stat_q <= 1'b1;
    end
  end

  assign done_o = done_q;
  assign stat_o = stat_q;

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q); // R6
  AST_DONE_NEEDS_FRAMES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> frames_done_i); // R6
  AST_LATE_AFTER_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && timing_sel_i == TSEL_LATE) |-> stat_q); // R7
endmodule

// File: rtl/cfg_stream_loader.sv
`timescale 1ns/1ps
module cfg_stream_loader #(
  parameter int unsigned PRE_ONES   = 8,
  parameter int unsigned CODE_W     = 4,
  parameter logic [CODE_W-1:0] PRE_CODE = 4'b0010,
  parameter int unsigned LEN_W      = 24,
  parameter int unsigned FRAME_W    = 8,
  parameter int unsigned NUM_FRAMES = 4,
  localparam int unsigned AW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               din_i,
  input  logic [1:0]         timing_sel_i,
  output logic               dout_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [FRAME_W-1:0] mem_data_o,
  output logic               done_o,
  output logic               user_rst_o,
  output logic               cfg_busy_o,
  output logic               cfg_busy_n_o
);
  logic             hdr_done, frames_done, done, stat;
  logic [LEN_W-1:0] len;
  logic             fwd_q, dout_q;

  cfg_hdr_parse #(
    .PRE_ONES(PRE_ONES), .CODE_W(CODE_W), .PRE_CODE(PRE_CODE), .LEN_W(LEN_W)
  ) u_hdr (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(din_i),
    .hdr_done_o(hdr_done), .len_o(len)
  );

  cfg_frame_asm #(
    .FRAME_W(FRAME_W), .NUM_FRAMES(NUM_FRAMES), .AW(AW)
  ) u_frm (
    .clk_i(clk_i), .rst_ni(rst_ni), .din_i(din_i), .hdr_done_i(hdr_done),
    .we_o(mem_we_o), .addr_o(mem_addr_o), .data_o(mem_data_o),
    .frames_done_o(frames_done)
  );

  cfg_done_ctrl #(.LEN_W(LEN_W)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .len_i(len), .frames_done_i(frames_done),
    .timing_sel_i(timing_sel_i), .done_o(done), .stat_o(stat)
  );

  // chain output: sample on rise, launch on fall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fwd_q <= 1'b1;
    else         fwd_q <= (hdr_done && !frames_done) ? 1'b1 : din_i;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dout_q <= 1'b1;
    else         dout_q <= fwd_q;
  end

  assign dout_o       = dout_q;
  assign done_o       = done;
  assign user_rst_o   = ~done;
  assign cfg_busy_o   = ~stat;
  assign cfg_busy_n_o = stat;

  AST_OWN_FRAMES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdr_done && !frames_done) |=> fwd_q); // R10
endmodule

// File: tb/cfg_stream_loader_test.sv
`timescale 1ns/1ps
module cfg_stream_loader_test;
  localparam int FW = 8;
  localparam int NF = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       din = 1'b1;
  logic [1:0] tsel = 2'b00;
  logic       dout, we, done, urst, busy, busy_n;
  logic [1:0] addr;
  logic [7:0] data;

  int total = 0;
  int bad = 0;

  logic stream [1:255];
  int   slen, hdr_end, frm_end;

  always #2.5 clk = ~clk;

  cfg_stream_loader uut (
    .clk_i(clk), .rst_ni(rst_ni), .din_i(din), .timing_sel_i(tsel),
    .dout_o(dout), .mem_we_o(we), .mem_addr_o(addr), .mem_data_o(data),
    .done_o(done), .user_rst_o(urst), .cfg_busy_o(busy), .cfg_busy_n_o(busy_n)
  );

  // [31:30] timing sel, [29] bad code first, [28:24] ones in run, [23:0] length
  localparam logic [31:0] VEC [7] = '{
    {2'b00, 1'b0, 5'd8,  24'd80},
    {2'b01, 1'b0, 5'd8,  24'd80},
    {2'b10, 1'b0, 5'd8,  24'd80},
    {2'b00, 1'b0, 5'd11, 24'd40},
    {2'b01, 1'b1, 5'd9,  24'd90},
    {2'b11, 1'b0, 5'd8,  24'd100},
    {2'b01, 1'b0, 5'd8,  24'd69}
  };

  function automatic logic [7:0] word_of(int f);
    return 8'(8'h3C + f * 71);
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic put(inout int n, input logic b);
    n++;
    stream[n] = b;
  endtask

  task automatic build(input bit badc, input int pre, input int len, input int tail);
    int n = 0;
    logic [3:0] code = 4'b0010;
    logic [23:0] l = 24'(len);
    logic [7:0] w;
    if (badc) begin
      for (int i = 0; i < 8; i++) put(n, 1'b1);
      put(n, 1'b0); put(n, 1'b1); put(n, 1'b1); put(n, 1'b0);
    end
    for (int i = 0; i < pre; i++) put(n, 1'b1);
    for (int i = 3; i >= 0; i--) put(n, code[i]);
    for (int i = 23; i >= 0; i--) put(n, l[i]);
    hdr_end = n;
    for (int f = 0; f < NF; f++) begin
      w = word_of(f);
      for (int i = FW - 1; i >= 0; i--) put(n, w[i]);
    end
    frm_end = n;
    while (n < tail) put(n, logic'((n % 3) == 1));
    slen = n;
  endtask

  task automatic check_reset_state(input string tag);
    chk(dout == 1'b1, {tag, " dout"}, dout, 1);
    chk(done == 1'b0, {tag, " done"}, done, 0);
    chk(urst == 1'b1, {tag, " user_rst"}, urst, 1);
    chk(we == 1'b0, {tag, " we"}, we, 0);
    chk(busy == 1'b1 && busy_n == 1'b0, {tag, " busy"}, {busy, busy_n}, 2);
  endtask

  task automatic run(input logic [31:0] v, input int stop_at);
    int len = int'(v[23:0]);
    int adj = (v[31:30] == 2'b01) ? -1 : (v[31:30] == 2'b10) ? 1 : 0;
    int exp_done, exp_stat, k;
    bit in_frm, exp_we;
    rst_ni = 1'b0;
    tsel = v[31:30];
    din = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_reset_state("R11 reset");
    build(v[29], int'(v[28:24]), len, 0);
    exp_done = imax(len + adj, frm_end) + 1;
    exp_stat = imax(len, frm_end) + 1;
    build(v[29], int'(v[28:24]), len, imax(exp_done, exp_stat) + 5);
    @(negedge clk);
    rst_ni = 1'b1;
    for (int n = 1; n <= slen && n <= stop_at; n++) begin
      din = stream[n];
      @(posedge clk);
      #1;
      chk(done == (n >= exp_done), "R4/R6/R7 done", done, int'(n >= exp_done));
      chk(urst == (n < exp_done), "R8 user_rst", urst, int'(n < exp_done));
      chk(busy == (n < exp_stat) && busy_n == (n >= exp_stat), "R9 status",
          busy, int'(n < exp_stat));
      in_frm = (n > hdr_end) && (n <= frm_end);
      exp_we = in_frm && ((n - hdr_end) % FW == 0);
      chk(we == exp_we, v[29] ? "R2 we" : "R1 we", we, int'(exp_we));
      if (exp_we && we) begin
        k = (n - hdr_end) / FW - 1;
        chk(int'(addr) == k, "R5 addr", addr, k);
        chk(data == word_of(k), "R3/R5 data", data, word_of(k));
      end
      @(negedge clk);
      #1;
      chk(dout == (in_frm ? 1'b1 : stream[n]), "R10 dout", dout,
          in_frm ? 1 : int'(stream[n]));
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (VEC[i]) run(VEC[i], 1000);
    // R11: asynchronous reset in the middle of frame loading
    run(VEC[0], 50);
    @(posedge clk);
    #1;
    rst_ni = 1'b0;
    #0.5;
    check_reset_state("R11 async");
    // R4: counter restarts, completion edge identical to the first run
    run(VEC[0], 1000);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule